// File: doc/BRIEF.md
# Size-Qualified Data Register Execute Unit

This block is the execute stage of an accumulator-style processor. It holds a bank of eight 32-bit data registers and accepts one decoded command per cycle. Each command names a destination register, a source operand (another register or an immediate), an operation and a size of byte, word or long. The result is written back on the clock edge that accepts the command. Only the byte lanes the size covers are written, and the other bits of the destination keep their old value. A five-bit condition flag register is updated on the same edge.

The operations are move, clear, add, subtract, compare, AND, OR, XOR, NOT, a quick load that sign-extends an 8-bit immediate, and four single-bit operations: test, set, clear and change. Condition flags are derived at the selected width, so a byte add sets carry and overflow from bit 7. A read port lets the surrounding pipeline, or a bench, look at any register.

Top module: `lane_alu`

## Requirements
- R1: After an asynchronous reset all eight registers read 0 and `flags_o` is 0. `flags_o` packs X in bit 4, N in bit 3, Z in bit 2, V in bit 1 and C in bit 0.
- R2: Size code 0 is byte, 1 is word, and 2 or 3 is long. A byte-sized write changes only bits 7..0 of the destination and a word-sized write changes only bits 15..0. All other bits keep their value.
- R3: Add (op 2) and subtract (op 3) work at the selected width. Carry or borrow stops at the sized MSB and is placed in both C and X. V flags signed overflow at that width. A word subtract of immediate 0x80 from 0x001122AB leaves 0x0011222B.
- R4: Compare (op 4) computes destination minus source and sets N, Z, V and C as subtract does. It leaves the destination and X unchanged.
- R5: Clear (op 1) zeroes only the sized lanes and sets Z=1, N=0, V=0 and C=0. X keeps its value.
- R6: Move (op 0), AND (op 5), OR (op 6), XOR (op 7) and NOT (op 8) clear V and C and keep X. N and Z come from the MSB and the zero test of the sized result. NOT writes the one's complement of the sized destination.
- R7: Quick load (op 9) sign-extends the low 8 bits of the source into all 32 bits, whatever the size. For example, 0x2C gives 0x0000002C and 0x8F gives 0xFFFFFF8F. N and Z follow the 32-bit result, V and C clear, and X keeps its value.
- R8: The bit operations take the bit number from the source's low 5 bits (modulo 32) and act on the full 32-bit destination. Each first sets Z to the inverse of the old bit, leaving N, V, C and X alone. Then test (op 10) writes nothing, set (op 11) forces the bit to 1, clear (op 12) forces it to 0, and change (op 13) inverts it.
- R9: The source is the immediate when `cmd_use_imm_i` is 1 and otherwise register `cmd_src_i`. With `cmd_valid_i` low, or with op code 14 or 15, no register or flag changes.
- R10: A command's result can be seen on the read port right after the edge that accepts it. A command issued in the very next cycle uses that result as its operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 4 | Operation code |
| cmd_size_i | input | 2 | Operand size code |
| cmd_dst_i | input | 3 | Destination register index |
| cmd_src_i | input | 3 | Source register index |
| cmd_use_imm_i | input | 1 | Take source from immediate |
| cmd_imm_i | input | 32 | Immediate operand or bit number |
| rd_addr_i | input | 3 | Read port register index |
| rd_data_o | output | 32 | Read port data |
| flags_o | output | 5 | Condition flags {X,N,Z,V,C} |

## Verification
The cases that matter most are those where a register's write-back and a later command's operand fetch of the same register fall in the same cycle. They also arise when a command's source and destination registers are the same. Random command streams are issued back to back, with register indices drawn from only eight values, so aliasing between neighbouring commands is common. Sized results, partial-lane merges and flags are judged against a bench model that updates its own register copy in command order. Directed cases pin the width-limited borrow, sign extension of the quick load, and X preservation across compare.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_LALT = 2'd3
  } size_e;

  typedef enum logic [3:0] {
    OP_MOVE  = 4'd0,
    OP_CLR   = 4'd1,
    OP_ADD   = 4'd2,
    OP_SUB   = 4'd3,
    OP_CMP   = 4'd4,
    OP_AND   = 4'd5,
    OP_OR    = 4'd6,
    OP_XOR   = 4'd7,
    OP_NOT   = 4'd8,
    OP_QUICK = 4'd9,
    OP_BTST  = 4'd10,
    OP_BSET  = 4'd11,
    OP_BCLR  = 4'd12,
    OP_BCHG  = 4'd13,
    OP_RSV14 = 4'd14,
    OP_RSV15 = 4'd15
  } op_e;

  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  localparam int LANE_W = 8;

endpackage

// File: rtl/lane_alu_regs.sv
module lane_alu_regs
  import lane_alu_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int DATA_W = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [$clog2(NREG)-1:0]     waddr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic [DATA_W/LANE_W-1:0]    wlane_i,
  input  logic [$clog2(NREG)-1:0]     raddr_a_i,
  output logic [DATA_W-1:0]           rdata_a_o,
  input  logic [$clog2(NREG)-1:0]     raddr_b_i,
  output logic [DATA_W-1:0]           rdata_b_o,
  input  logic [$clog2(NREG)-1:0]     raddr_c_i,
  output logic [DATA_W-1:0]           rdata_c_o
);
  localparam int AW    = $clog2(NREG);
  localparam int NLANE = DATA_W / LANE_W;

  logic [DATA_W-1:0] words [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    // per-lane enables merge sized results into the untouched upper bits
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= '0;
      end else if (we_i && waddr_i == AW'(g)) begin
        for (int l = 0; l < NLANE; l++) begin
          if (wlane_i[l]) q[l*LANE_W +: LANE_W] <= wdata_i[l*LANE_W +: LANE_W];
        end
      end
    end
    assign words[g] = q;
  end

  assign rdata_a_o = words[raddr_a_i];
  assign rdata_b_o = words[raddr_b_i];
  assign rdata_c_o = words[raddr_c_i];

endmodule

// File: rtl/lane_alu_exec.sv
module lane_alu_exec
  import lane_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  op_e               op_i,
  input  size_e             size_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  flags_t            flags_i,
  output logic              we_o,
  output logic              full_o,
  output logic [DATA_W-1:0] wdata_o,
  output flags_t            flags_o
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam int MSB   = DATA_W - 1;

  logic [BIT_W-1:0]  sh;
  logic [DATA_W-1:0] da, sa, amask, r, bmask;
  logic [DATA_W:0]   sum, dif;
  logic              sized, bold;

  // operands are left-aligned so the sized MSB sits at bit MSB: one adder serves all widths
  always_comb begin
    unique case (size_i)
      SZ_BYTE: sh = BIT_W'(DATA_W - 8);
      SZ_WORD: sh = BIT_W'(DATA_W - 16);
      default: sh = '0;
    endcase
    amask = {DATA_W{1'b1}} << sh;
    da    = dst_i << sh;
    sa    = src_i << sh;
    sum   = {1'b0, da} + {1'b0, sa};
    dif   = {1'b0, da} - {1'b0, sa};
    bmask = {{(DATA_W-1){1'b0}}, 1'b1} << src_i[BIT_W-1:0];
    bold  = |(dst_i & bmask);

    we_o    = 1'b0;
    full_o  = 1'b0;
    sized   = 1'b0;
    r       = '0;
    wdata_o = '0;
    flags_o = flags_i;

    case (op_i)
      OP_MOVE, OP_CLR, OP_AND, OP_OR, OP_XOR, OP_NOT: begin
        case (op_i)
          OP_MOVE: r = sa;
          OP_AND:  r = da & sa;
          OP_OR:   r = da | sa;
          OP_XOR:  r = da ^ sa;
          OP_NOT:  r = ~da;
          default: r = '0;
        endcase
        sized     = 1'b1;
        we_o      = 1'b1;
        flags_o.v = 1'b0;
        flags_o.c = 1'b0;
      end
      OP_ADD: begin
        r         = sum[MSB:0];
        sized     = 1'b1;
        we_o      = 1'b1;
        flags_o.c = sum[DATA_W];
        flags_o.x = sum[DATA_W];
        flags_o.v = (da[MSB] == sa[MSB]) && (sum[MSB] != da[MSB]);
      end
      OP_SUB, OP_CMP: begin
        r         = dif[MSB:0];
        sized     = 1'b1;
        we_o      = (op_i == OP_SUB);
        flags_o.c = dif[DATA_W];
        if (op_i == OP_SUB) flags_o.x = dif[DATA_W];
        flags_o.v = (da[MSB] != sa[MSB]) && (dif[MSB] != da[MSB]);
      end
      OP_QUICK: begin
        wdata_o   = {{(DATA_W-8){src_i[7]}}, src_i[7:0]};
        we_o      = 1'b1;
        full_o    = 1'b1;
        flags_o.n = src_i[7];
        flags_o.z = ~|src_i[7:0];
        flags_o.v = 1'b0;
        flags_o.c = 1'b0;
      end
      OP_BTST, OP_BSET, OP_BCLR, OP_BCHG: begin
        flags_o.z = ~bold;
        full_o    = 1'b1;
        we_o      = (op_i != OP_BTST);
        case (op_i)
          OP_BSET: wdata_o = dst_i | bmask;
          OP_BCLR: wdata_o = dst_i & ~bmask;
          OP_BCHG: wdata_o = dst_i ^ bmask;
          default: wdata_o = dst_i;
        endcase
      end
      default: ;
    endcase

    if (sized) begin
      r         = r & amask;
      wdata_o   = r >> sh;
      flags_o.n = r[MSB];
      flags_o.z = ~|r;
    end
  end

endmodule

// File: rtl/lane_alu.sv
module lane_alu
  import lane_alu_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int DATA_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cmd_valid_i,
  input  logic [3:0]              cmd_op_i,
  input  logic [1:0]              cmd_size_i,
  input  logic [$clog2(NREG)-1:0] cmd_dst_i,
  input  logic [$clog2(NREG)-1:0] cmd_src_i,
  input  logic                    cmd_use_imm_i,
  input  logic [DATA_W-1:0]       cmd_imm_i,
  input  logic [$clog2(NREG)-1:0] rd_addr_i,
  output logic [DATA_W-1:0]       rd_data_o,
  output logic [4:0]              flags_o
);
  localparam int NLANE = DATA_W / LANE_W;

  logic [DATA_W-1:0] dst_val, src_reg, src_val, wdata;
  logic [NLANE-1:0]  lane_sel;
  logic              ex_we, ex_full;
  flags_t            flag_q, ex_flags;
  size_e             size;

  assign size    = size_e'(cmd_size_i);
  assign src_val = cmd_use_imm_i ? cmd_imm_i : src_reg;

  lane_alu_regs #(.NREG(NREG), .DATA_W(DATA_W)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cmd_valid_i & ex_we),
    .waddr_i   (cmd_dst_i),
    .wdata_i   (wdata),
    .wlane_i   (lane_sel),
    .raddr_a_i (cmd_dst_i),
    .rdata_a_o (dst_val),
    .raddr_b_i (cmd_src_i),
    .rdata_b_o (src_reg),
    .raddr_c_i (rd_addr_i),
    .rdata_c_o (rd_data_o)
  );

  lane_alu_exec #(.DATA_W(DATA_W)) i_exec (
    .op_i    (op_e'(cmd_op_i)),
    .size_i  (size),
    .dst_i   (dst_val),
    .src_i   (src_val),
    .flags_i (flag_q),
    .we_o    (ex_we),
    .full_o  (ex_full),
    .wdata_o (wdata),
    .flags_o (ex_flags)
  );

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    assign lane_sel[l] = ex_full
                       | ((size == SZ_BYTE) ? (l == 0)
                       :  (size == SZ_WORD) ? (l < 2) : 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          flag_q <= '0;
    else if (cmd_valid_i) flag_q <= ex_flags;
  end

  assign flags_o = flag_q;

endmodule

// File: rtl/lane_alu_chk.sv
module lane_alu_chk #(
  parameter int AW     = 3,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [3:0]        cmd_op_i,
  input logic [1:0]        cmd_size_i,
  input logic [AW-1:0]     cmd_dst_i,
  input logic              cmd_use_imm_i,
  input logic [7:0]        imm8_i,
  input logic [AW-1:0]     rd_addr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [4:0]        flags_o
);

  assert_upper_keep_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_size_i == 2'd0 && cmd_op_i <= 4'd8 && rd_addr_i == cmd_dst_i)
    |=> (rd_addr_i != $past(rd_addr_i)) || (rd_data_o[DATA_W-1:8] == $past(rd_data_o[DATA_W-1:8])));

  assert_carry_ext_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && (cmd_op_i == 4'd2 || cmd_op_i == 4'd3)) |=> (flags_o[4] == flags_o[0]));

  assert_cmp_keep_x_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 4'd4) |=> (flags_o[4] == $past(flags_o[4])));

  assert_clear_flags_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 4'd1) |=> (flags_o[3:0] == 4'b0100) && $stable(flags_o[4]));

  assert_logic_vc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && (cmd_op_i == 4'd0 || (cmd_op_i >= 4'd5 && cmd_op_i <= 4'd8)))
    |=> (flags_o[1:0] == 2'b00) && $stable(flags_o[4]));

  assert_quick_nz_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 4'd9 && cmd_use_imm_i)
    |=> (flags_o[3] == $past(imm8_i[7])) && (flags_o[2] == ($past(imm8_i) == 8'd0))
        && (flags_o[1:0] == 2'b00));

  assert_bit_flags_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i >= 4'd10 && cmd_op_i <= 4'd13)
    |=> $stable(flags_o[4:3]) && $stable(flags_o[1:0]));

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_valid_i || cmd_op_i >= 4'd14) |=> $stable(flags_o));

endmodule

bind lane_alu lane_alu_chk #(.AW($clog2(NREG)), .DATA_W(DATA_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cmd_valid_i   (cmd_valid_i),
  .cmd_op_i      (cmd_op_i),
  .cmd_size_i    (cmd_size_i),
  .cmd_dst_i     (cmd_dst_i),
  .cmd_use_imm_i (cmd_use_imm_i),
  .imm8_i        (cmd_imm_i[7:0]),
  .rd_addr_i     (rd_addr_i),
  .rd_data_o     (rd_data_o),
  .flags_o       (flags_o)
);

// File: tb/test_lane_alu.sv
`timescale 1ns/1ps
module test_lane_alu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_op = '0;
  logic [1:0]  cmd_size = '0;
  logic [2:0]  cmd_dst = '0;
  logic [2:0]  cmd_src = '0;
  logic        cmd_use_imm = 1'b0;
  logic [31:0] cmd_imm = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [4:0]  flags;

  logic [31:0] mreg [8];
  logic [4:0]  mfl;
  int          nchk = 0;
  int          nerr = 0;

  always #10 clk = ~clk;

  lane_alu i_lane_alu (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .cmd_valid_i   (cmd_valid),
    .cmd_op_i      (cmd_op),
    .cmd_size_i    (cmd_size),
    .cmd_dst_i     (cmd_dst),
    .cmd_src_i     (cmd_src),
    .cmd_use_imm_i (cmd_use_imm),
    .cmd_imm_i     (cmd_imm),
    .rd_addr_i     (rd_addr),
    .rd_data_o     (rd_data),
    .flags_o       (flags)
  );

  task automatic check(input logic [31:0] exp_d, input logic [4:0] exp_f, input string tag);
    nchk++;
    if (rd_data !== exp_d || flags !== exp_f) begin
      nerr++;
      $display("FAIL %s: reg=%h flags=%b expected reg=%h flags=%b", tag, rd_data, flags, exp_d, exp_f);
    end
  endtask

  // reference model, written per width with masks
  task automatic model(input int op, input int sz, input int dst, input int src,
                       input logic ui, input logic [31:0] imm);
    int w, bn;
    logic [63:0] msk, a, b, t;
    logic [31:0] d, s, r;
    logic c, v;
    w   = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    msk = (64'd1 << w) - 64'd1;
    d   = mreg[dst];
    s   = ui ? imm : mreg[src];
    a   = {32'd0, d} & msk;
    b   = {32'd0, s} & msk;
    case (op)
      0, 1, 5, 6, 7, 8: begin
        case (op)
          0: t = b;
          1: t = '0;
          5: t = a & b;
          6: t = a | b;
          7: t = a ^ b;
          default: t = ~a & msk;
        endcase
        r = t[31:0];
        mreg[dst] = (d & ~msk[31:0]) | r;
        mfl = {mfl[4], r[w-1], r == 32'd0, 2'b00};
      end
      2: begin
        t = a + b;
        r = t[31:0] & msk[31:0];
        c = t[w];
        v = (a[w-1] == b[w-1]) && (r[w-1] != a[w-1]);
        mreg[dst] = (d & ~msk[31:0]) | r;
        mfl = {c, r[w-1], r == 32'd0, v, c};
      end
      3, 4: begin
        t = a - b;
        r = t[31:0] & msk[31:0];
        c = (a < b);
        v = (a[w-1] != b[w-1]) && (r[w-1] != a[w-1]);
        if (op == 3) begin
          mreg[dst] = (d & ~msk[31:0]) | r;
          mfl = {c, r[w-1], r == 32'd0, v, c};
        end else begin
          mfl = {mfl[4], r[w-1], r == 32'd0, v, c};
        end
      end
      9: begin
        r = {{24{s[7]}}, s[7:0]};
        mreg[dst] = r;
        mfl = {mfl[4], r[31], r == 32'd0, 2'b00};
      end
      10, 11, 12, 13: begin
        bn = int'(s[4:0]);
        mfl[2] = ~d[bn];
        if (op == 11) d[bn] = 1'b1;
        if (op == 12) d[bn] = 1'b0;
        if (op == 13) d[bn] = ~d[bn];
        if (op != 10) mreg[dst] = d;
      end
      default: ;
    endcase
  endtask

  // called at a negedge; with chk the result is compared one cycle later
  task automatic issue(input logic vld, input int op, input int sz, input int dst, input int src,
                       input logic ui, input logic [31:0] imm, input bit chk, input string tag);
    cmd_valid   = vld;
    cmd_op      = 4'(op);
    cmd_size    = 2'(sz);
    cmd_dst     = 3'(dst);
    cmd_src     = 3'(src);
    cmd_use_imm = ui;
    cmd_imm     = imm;
    rd_addr     = 3'(dst);
    if (vld) model(op, sz, dst, src, ui, imm);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (chk) begin
      #1;
      check(mreg[dst], mfl, tag);
    end
  endtask

  function automatic string tag_of(input int op);
    case (op)
      0, 5, 6, 7, 8:    return "R6";
      1:                return "R5";
      2, 3:             return "R3";
      4:                return "R4";
      9:                return "R7";
      10, 11, 12, 13:   return "R8";
      default:          return "R9";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL R10 watchdog: cycles=200000 expected earlier completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] imm;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) mreg[i] = '0;
    mfl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of every register and the flags
    for (int i = 0; i < 8; i++) begin
      rd_addr = 3'(i);
      #1;
      check(32'd0, 5'd0, "R1");
    end
    @(negedge clk);

    // R3: word subtract borrow stays below bit 16
    issue(1, 0, 2, 1, 0, 1, 32'h001122AB, 1, "R6");
    issue(1, 3, 1, 1, 0, 1, 32'h00000080, 1, "R3");
    if (mreg[1] != 32'h0011222B) $display("FAIL R3: model=%h expected reg=0011222b", mreg[1]);
    // R5: byte clear keeps upper bits
    issue(1, 1, 0, 1, 0, 1, 32'h0, 1, "R5");
    // R2: byte move into a full register
    issue(1, 0, 2, 4, 0, 1, 32'h12345678, 1, "R2");
    issue(1, 0, 0, 4, 0, 1, 32'hFFFFFF55, 1, "R2");
    issue(1, 0, 1, 4, 0, 1, 32'hFFFF8001, 1, "R2");
    // R7: quick load sign extension
    issue(1, 0, 2, 3, 0, 1, 32'h1234562C, 1, "R6");
    issue(1, 9, 0, 3, 0, 1, 32'h0000002C, 1, "R7");
    issue(1, 9, 1, 3, 0, 1, 32'h0000008F, 1, "R7");
    // R3: word add carry out with zero result, sets X
    issue(1, 0, 2, 2, 0, 1, 32'hAAAAFFFF, 1, "R6");
    issue(1, 2, 1, 2, 0, 1, 32'h00000001, 1, "R3");
    // R4: compare keeps X=1 and the destination
    issue(1, 4, 2, 2, 0, 1, 32'h00000005, 1, "R4");
    // R8: bit set with bit number 40 acts on bit 8
    issue(1, 11, 0, 2, 0, 1, 32'd40, 1, "R8");
    issue(1, 10, 0, 2, 0, 1, 32'd8, 1, "R8");
    issue(1, 13, 2, 2, 0, 1, 32'd31, 1, "R8");
    // R9: idle cycle and reserved op change nothing
    issue(0, 2, 2, 2, 0, 1, 32'h11111111, 1, "R9");
    issue(1, 14, 2, 2, 0, 1, 32'h11111111, 1, "R9");
    issue(1, 15, 0, 2, 2, 0, 32'h0, 1, "R9");
    // R10: back-to-back dependent commands
    issue(1, 0, 2, 5, 0, 1, 32'h0000007F, 0, "R10");
    issue(1, 2, 0, 6, 5, 0, 32'h0, 0, "R10");
    issue(1, 2, 0, 6, 5, 0, 32'h0, 1, "R10");

    // random phase: seed registers, then mixed streams with aliasing
    for (int i = 0; i < 8; i++) issue(1, 0, 2, i, 0, 1, $urandom, 1, "R6");
    for (int n = 0; n < 600; n++) begin
      int op;
      op = int'($urandom % 16);
      case ($urandom % 6)
        0: imm = 32'h0;
        1: imm = 32'h80;
        2: imm = 32'h7F;
        3: imm = 32'hFFFF;
        4: imm = 32'h8000;
        default: imm = $urandom;
      endcase
      issue(1, op, int'($urandom % 4), int'($urandom % 8), int'($urandom % 8),
            1'($urandom % 2), imm, ($urandom % 4) != 0, tag_of(op));
    end
    issue(0, 0, 0, 0, 0, 0, 32'h0, 1, "R10");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule